// File: doc/BRIEF.md
# Quasi-Bidirectional GPIO Port Controller

This block owns three 8-bit general-purpose ports on the special-function-register (SFR) bus of an 8051-style microcontroller. Each pin has an output latch bit and a pull-up disable bit. From these the block produces three pad controls per pin: an output enable, a driven data value and a weak pull-up enable. A pin whose latch holds 0 is driven low. A pin whose latch holds 1 is released, and it floats high through the weak pull-up unless its pull-up has been turned off, in which case it is open drain. A released pin therefore also serves as an input.

Byte reads pick one of two sources on every access. Read-modify-write instructions take the latch contents. Plain moves take the pad level, which passes through a two-flop synchronizer first. Single-bit writes go through the latch path in a two-cycle read-modify-write. When a peripheral claims a pin through its alternate-function enable, that peripheral's output enable and data go to the pad in place of the latch.

Accesses are sequenced by a small state machine:
- `ST_IDLE` accepts strobes.
- `ST_IDLE`→`ST_READ` is taken on an accepted byte read. `ST_READ`→`ST_IDLE` always follows one cycle later, and `rd_valid` is high while in `ST_READ`.
- `ST_IDLE`→`ST_RMW` is taken on an accepted bit write. `ST_RMW`→`ST_IDLE` always follows one cycle later, and the merged byte is written back while in `ST_RMW`.
- Byte writes complete inside `ST_IDLE` without leaving it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every latch bit is 1 and every pull-up disable bit is 0, so `pad_oe` is all 0, `pad_pu` is all 1 and `pad_do` is all 0. `busy` and `rd_valid` are 0.
- R2: A byte write accepted in `ST_IDLE` to port address 0x80, 0x90 or 0xA0 (ports 0, 1, 2) loads `sfr_wdata` into that port's latch at that clock edge.
- R3: The pull-up disable registers of ports 0, 1 and 2 sit at 0xB2, 0xB3 and 0xB4. They read back what was written. On a released pin (latch 1, no alternate function), bit value 1 makes `pad_pu` 0 (open drain) and bit value 0 makes it 1.
- R4: A pin without an alternate function and with latch 0 has `pad_oe`=1, `pad_do`=0 and `pad_pu`=0. With latch 1 it has `pad_oe`=0, `pad_do`=0 and `pad_pu` equal to the inverse of its pull-up disable bit. `pad_oe` and `pad_pu` are never both 1 on the same pin.
- R5: A read with `rd_from_pin`=1 returns the pad level through a two-flop synchronizer. A pad change set up before edge E is returned by a read accepted at edge E+2 or later. A read accepted at edge E+1 still returns the previous level.
- R6: A read with `rd_from_pin`=0 of a port address returns the latch, whatever the pad level.
- R7: An accepted read raises `rd_valid` for exactly the one cycle after the accepting edge, with `sfr_rdata` valid. `sfr_rdata` holds until the next accepted read.
- R8: A bit write uses bit address = port address + bit index (0x80–0x87, 0x90–0x97, 0xA0–0xA7). It changes only that latch bit to `bit_val`, and the other bits come from the latch, not from the pads. `busy` is 1 for the one cycle after acceptance, and the latch takes the new value at the following edge.
- R9: Byte writes, bit writes and reads that arrive while `busy` is 1 are ignored.
- R10: A pin with `alt_en`=1 takes `pad_oe`=`alt_oe` and `pad_do`=`alt_do`. Its `pad_pu` is 1 only if `alt_oe` is 0 and its pull-up is enabled. Its latch is left unchanged.
- R11: Writes to any other SFR address change nothing, and reads of them return 0x00. A bit write outside the three bit ranges is not accepted (`busy` stays 0).
- R12: When strobes coincide in `ST_IDLE`, a byte write wins over a bit write, and a bit write wins over a read. Only the winner is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address for byte writes and reads |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_rd | input | 1 | Byte read strobe |
| rd_from_pin | input | 1 | Read source: 1 = synchronized pad level, 0 = latch |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address of a bit write |
| bit_val | input | 1 | Value for a bit write |
| busy | output | 1 | Read-modify-write write-back in progress |
| alt_en | input | 24 | Per-pin alternate-function claim |
| alt_oe | input | 24 | Per-pin alternate-function output enable |
| alt_do | input | 24 | Per-pin alternate-function output data |
| pad_in | input | 24 | Pad levels (asynchronous) |
| pad_oe | output | 24 | Pad output enable |
| pad_do | output | 24 | Pad output data |
| pad_pu | output | 24 | Pad weak pull-up enable |

## Verification
The bench writes all 256 values to each port and checks both the latch read and every pad control. If the drive decode is inverted or the wrong port is addressed, the pad vectors would go wrong. It drives the pads opposite to the latch during latch reads and bit writes. A read or merge taken from the wrong source would then return the pad pattern. It reads the pins once immediately after a pad change and once more later, so a synchronizer that is missing a stage or has one too many gives itself away. Strobes are also issued during `busy`, together in one cycle, and to unmapped addresses. A sequencer that accepts a strobe it should refuse would corrupt a latch or raise `rd_valid` at the wrong time.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_RMW  = 2'd2
    } acc_state_e;

    localparam logic [7:0] PORT_DATA_BASE = 8'h80;
    localparam logic [7:0] PORT_DATA_STEP = 8'h10;
    localparam logic [7:0] PULL_CFG_BASE  = 8'hB2;

    function automatic logic [7:0] port_data_addr(input int k);
        return PORT_DATA_BASE + PORT_DATA_STEP * 8'(k);
    endfunction

    function automatic logic [7:0] port_pull_addr(input int k);
        return PULL_CFG_BASE + 8'(k);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int   W       = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int PW     = 8,
    parameter int PIDXW  = 2,
    parameter int BIDXW  = 3
) (
    input  logic [7:0]       sfr_addr,
    input  logic [7:0]       bit_addr,
    output logic             data_hit,
    output logic [PIDXW-1:0] data_port,
    output logic             pull_hit,
    output logic [PIDXW-1:0] pull_port,
    output logic             bit_hit,
    output logic [PIDXW-1:0] bit_port,
    output logic [BIDXW-1:0] bit_idx
);
    localparam logic [7:0] BIT_MASK = ~8'(PW - 1);

    always_comb begin
        data_hit  = 1'b0;
        data_port = '0;
        pull_hit  = 1'b0;
        pull_port = '0;
        bit_hit   = 1'b0;
        bit_port  = '0;
        bit_idx   = bit_addr[BIDXW-1:0];
        for (int k = 0; k < NPORTS; k++) begin
            if (sfr_addr == port_data_addr(k)) begin
                data_hit  = 1'b1;
                data_port = PIDXW'(k);
            end
            if (sfr_addr == port_pull_addr(k)) begin
                pull_hit  = 1'b1;
                pull_port = PIDXW'(k);
            end
            if ((bit_addr & BIT_MASK) == port_data_addr(k)) begin
                bit_hit  = 1'b1;
                bit_port = PIDXW'(k);
            end
        end
    end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
    parameter int W = 24
) (
    input  logic [W-1:0] latch,
    input  logic [W-1:0] pull_off,
    input  logic [W-1:0] alt_en,
    input  logic [W-1:0] alt_oe,
    input  logic [W-1:0] alt_do,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_do,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        // GPIO: only a 0 is driven; a 1 releases the pin to the pull-up or to open drain
        assign pad_oe[i] = alt_en[i] ? alt_oe[i] : ~latch[i];
        assign pad_do[i] = alt_en[i] & alt_do[i];
        assign pad_pu[i] = ~pull_off[i] & (alt_en[i] ? ~alt_oe[i] : latch[i]);
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int PW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           sfr_addr,
    input  logic                 sfr_wr,
    input  logic                 sfr_rd,
    input  logic                 rd_from_pin,
    input  logic [PW-1:0]        sfr_wdata,
    output logic [PW-1:0]        sfr_rdata,
    output logic                 rd_valid,
    input  logic                 bit_wr,
    input  logic [7:0]           bit_addr,
    input  logic                 bit_val,
    output logic                 busy,
    input  logic [NPORTS*PW-1:0] alt_en,
    input  logic [NPORTS*PW-1:0] alt_oe,
    input  logic [NPORTS*PW-1:0] alt_do,
    input  logic [NPORTS*PW-1:0] pad_in,
    output logic [NPORTS*PW-1:0] pad_oe,
    output logic [NPORTS*PW-1:0] pad_do,
    output logic [NPORTS*PW-1:0] pad_pu
);
    localparam int TOT   = NPORTS * PW;
    localparam int PIDXW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int BIDXW = (PW > 1) ? $clog2(PW) : 1;

    acc_state_e state_q, state_d;

    logic [NPORTS-1:0][PW-1:0] latch_q;
    logic [NPORTS-1:0][PW-1:0] pull_off_q;
    logic [PIDXW-1:0]          rmw_port_q;
    logic [PW-1:0]             rmw_data_q;
    logic [PW-1:0]             rdata_q;

    logic [TOT-1:0]   pin_sync;
    logic [TOT-1:0]   latch_flat;
    logic [TOT-1:0]   pull_flat;
    logic             data_hit, pull_hit, bit_hit;
    logic [PIDXW-1:0] data_port, pull_port, bit_port;
    logic [BIDXW-1:0] bit_idx;
    logic             idle, take_wr, take_bit, take_rd;
    logic [PW-1:0]    rd_mux;
    logic [PW-1:0]    rmw_merge;

    gpio_sync #(.W(TOT), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    gpio_addr_dec #(
        .NPORTS (NPORTS),
        .PW     (PW),
        .PIDXW  (PIDXW),
        .BIDXW  (BIDXW)
    ) u_dec (
        .sfr_addr  (sfr_addr),
        .bit_addr  (bit_addr),
        .data_hit  (data_hit),
        .data_port (data_port),
        .pull_hit  (pull_hit),
        .pull_port (pull_port),
        .bit_hit   (bit_hit),
        .bit_port  (bit_port),
        .bit_idx   (bit_idx)
    );

    // Strobe acceptance: byte write > bit write > read, only in ST_IDLE
    assign idle     = (state_q == ST_IDLE);
    assign take_wr  = idle & sfr_wr;
    assign take_bit = idle & ~sfr_wr & bit_wr & bit_hit;
    assign take_rd  = idle & ~sfr_wr & ~bit_wr & sfr_rd;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_bit) begin
                    state_d = ST_RMW;
                end else if (take_rd) begin
                    state_d = ST_READ;
                end
            end
            ST_READ: state_d = ST_IDLE;
            ST_RMW:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        busy     = 1'b0;
        rd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: rd_valid = 1'b1;
            ST_RMW:  busy     = 1'b1;
            default: ;
        endcase
    end

    // Read source selection
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NPORTS; k++) begin
            if (data_hit && data_port == PIDXW'(k)) begin
                rd_mux = rd_from_pin ? pin_sync[k*PW +: PW] : latch_q[k];
            end
            if (pull_hit && pull_port == PIDXW'(k)) begin
                rd_mux = pull_off_q[k];
            end
        end
    end

    // Bit merge always starts from the latch, never from the pad
    always_comb begin
        rmw_merge = '0;
        for (int k = 0; k < NPORTS; k++) begin
            if (bit_port == PIDXW'(k)) begin
                rmw_merge = latch_q[k];
            end
        end
        rmw_merge[bit_idx] = bit_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q    <= '1;
            pull_off_q <= '0;
            rmw_port_q <= '0;
            rmw_data_q <= '0;
            rdata_q    <= '0;
        end else begin
            if (take_wr && data_hit) begin
                latch_q[data_port] <= sfr_wdata;
            end
            if (take_wr && pull_hit) begin
                pull_off_q[pull_port] <= sfr_wdata;
            end
            if (take_bit) begin
                rmw_port_q <= bit_port;
                rmw_data_q <= rmw_merge;
            end
            if (state_q == ST_RMW) begin
                latch_q[rmw_port_q] <= rmw_data_q;
            end
            if (take_rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign sfr_rdata  = rdata_q;
    assign latch_flat = latch_q;
    assign pull_flat  = pull_off_q;

    gpio_pin_drive #(.W(TOT)) u_drive (
        .latch    (latch_flat),
        .pull_off (pull_flat),
        .alt_en   (alt_en),
        .alt_oe   (alt_oe),
        .alt_do   (alt_do),
        .pad_oe   (pad_oe),
        .pad_do   (pad_do),
        .pad_pu   (pad_pu)
    );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int NPORTS = 3,
    parameter int PW     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [7:0]           sfr_addr,
    input logic                 sfr_wr,
    input logic                 sfr_rd,
    input logic [PW-1:0]        sfr_wdata,
    input logic                 bit_wr,
    input logic [7:0]           bit_addr,
    input logic                 busy,
    input logic                 rd_valid,
    input logic [NPORTS*PW-1:0] alt_en,
    input logic [NPORTS*PW-1:0] alt_oe,
    input logic [NPORTS*PW-1:0] pad_oe,
    input logic [NPORTS*PW-1:0] pad_do,
    input logic [NPORTS*PW-1:0] pad_pu
);
    assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && !sfr_wr && !bit_wr && !busy && !rd_valid) |=> rd_valid);

    assert_rd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_rmw_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr && !sfr_wr && !busy && !rd_valid && bit_addr[7:3] == 5'h10) |=> busy);

    assert_busy_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_no_fight_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);

    assert_gpio_low_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_do & ~alt_en) == '0);

    assert_alt_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ alt_oe) & alt_en) == '0);

    assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && !busy && !rd_valid && sfr_addr == 8'h80)
        |=> ((pad_oe[PW-1:0] ^ ~$past(sfr_wdata)) & ~alt_en[PW-1:0]) == '0);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPORTS(NPORTS), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_rd    (sfr_rd),
    .sfr_wdata (sfr_wdata),
    .bit_wr    (bit_wr),
    .bit_addr  (bit_addr),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .alt_en    (alt_en),
    .alt_oe    (alt_oe),
    .pad_oe    (pad_oe),
    .pad_do    (pad_do),
    .pad_pu    (pad_pu)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
    localparam int NP  = 3;
    localparam int PW  = 8;
    localparam int TOT = NP * PW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     sfr_addr = '0;
    logic           sfr_wr = 1'b0;
    logic           sfr_rd = 1'b0;
    logic           rd_from_pin = 1'b0;
    logic [PW-1:0]  sfr_wdata = '0;
    logic [PW-1:0]  sfr_rdata;
    logic           rd_valid;
    logic           bit_wr = 1'b0;
    logic [7:0]     bit_addr = '0;
    logic           bit_val = 1'b0;
    logic           busy;
    logic [TOT-1:0] alt_en = '0;
    logic [TOT-1:0] alt_oe = '0;
    logic [TOT-1:0] alt_do = '0;
    logic [TOT-1:0] pad_in = '1;
    logic [TOT-1:0] pad_oe, pad_do, pad_pu;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] m_latch [NP];
    logic [7:0] m_pull  [NP];

    always #4 clk = ~clk;

    gpio_port_ctrl #(.NPORTS(NP), .PW(PW)) i_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_rd(sfr_rd), .rd_from_pin(rd_from_pin), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .rd_valid(rd_valid), .bit_wr(bit_wr),
        .bit_addr(bit_addr), .bit_val(bit_val), .busy(busy),
        .alt_en(alt_en), .alt_oe(alt_oe), .alt_do(alt_do), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
    );

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] da(input int k);
        return 8'h80 + 8'(k * 16);
    endfunction

    function automatic logic [7:0] pa(input int k);
        return 8'hB2 + 8'(k);
    endfunction

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic rd_byte(input logic [7:0] a, input bit pin, output logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; rd_from_pin = pin; sfr_rd = 1'b1;
        @(negedge clk);
        sfr_rd = 1'b0;
        d = sfr_rdata;
        chk(rd_valid == 1'b1, "R7 rd_valid after read", 32'(rd_valid), 32'd1);
    endtask

    task automatic wr_bit(input logic [7:0] a, input logic v);
        @(negedge clk);
        bit_addr = a; bit_val = v; bit_wr = 1'b1;
        @(negedge clk);
        bit_wr = 1'b0;
        chk(busy == 1'b1, "R8 busy during write-back", 32'(busy), 32'd1);
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy released", 32'(busy), 32'd0);
    endtask

    task automatic check_pads(input string tag);
        logic [TOT-1:0] eo, ed, ep;
        #1;
        for (int p = 0; p < NP; p++) begin
            for (int i = 0; i < PW; i++) begin
                int n = p * PW + i;
                if (alt_en[n]) begin
                    eo[n] = alt_oe[n];
                    ed[n] = alt_do[n];
                    ep[n] = ~alt_oe[n] & ~m_pull[p][i];
                end else begin
                    eo[n] = ~m_latch[p][i];
                    ed[n] = 1'b0;
                    ep[n] = m_latch[p][i] & ~m_pull[p][i];
                end
            end
        end
        chk(pad_oe == eo, {tag, " pad_oe"}, 32'(pad_oe), 32'(eo));
        chk(pad_do == ed, {tag, " pad_do"}, 32'(pad_do), 32'(ed));
        chk(pad_pu == ep, {tag, " pad_pu"}, 32'(pad_pu), 32'(ep));
    endtask

    task automatic check_regs(input string tag);
        logic [7:0] d;
        for (int p = 0; p < NP; p++) begin
            rd_byte(da(p), 1'b0, d);
            chk(d == m_latch[p], {tag, " latch"}, 32'(d), 32'(m_latch[p]));
            rd_byte(pa(p), 1'b0, d);
            chk(d == m_pull[p], {tag, " pull"}, 32'(d), 32'(m_pull[p]));
        end
    endtask

    initial begin
        logic [7:0] d, d2, prev;
        for (int p = 0; p < NP; p++) begin
            m_latch[p] = 8'hFF;
            m_pull[p]  = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
        chk(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        check_pads("R1 reset");
        check_regs("R1 reset");

        // R2 R4 R6: every value on every port, pads held opposite to the latch
        for (int p = 0; p < NP; p++) begin
            for (int v = 0; v < 256; v++) begin
                pad_in = {NP{~8'(v)}};
                wr_byte(da(p), 8'(v));
                m_latch[p] = 8'(v);
                check_pads("R2 R4 byte write");
                rd_byte(da(p), 1'b0, d);
                chk(d == 8'(v), "R2 R6 latch read", 32'(d), 32'(v));
            end
            wr_byte(da(p), 8'hFF);
            m_latch[p] = 8'hFF;
        end

        // R3: pull-up disable patterns with mixed latch
        for (int p = 0; p < NP; p++) begin
            wr_byte(da(p), 8'h0F);
            m_latch[p] = 8'h0F;
            for (int j = 0; j < 5; j++) begin
                logic [7:0] pat;
                pat = (j == 0) ? 8'h00 : (j == 1) ? 8'hFF : (j == 2) ? 8'hA5 : (j == 3) ? 8'h3C : 8'h0F;
                wr_byte(pa(p), pat);
                m_pull[p] = pat;
                check_pads("R3 pull-up pattern");
                rd_byte(pa(p), 1'b0, d);
                chk(d == pat, "R3 pull readback", 32'(d), 32'(pat));
            end
            wr_byte(pa(p), 8'h00);
            m_pull[p] = 8'h00;
            wr_byte(da(p), 8'hFF);
            m_latch[p] = 8'hFF;
        end

        // R5: synchronizer latency on the pin path
        pad_in = '0;
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            for (int v = 0; v < 256; v++) begin
                prev = pad_in[p*PW +: PW];
                pad_in[p*PW +: PW] = 8'(v);
                rd_byte(da(p), 1'b1, d);
                chk(d == prev, "R5 pin read one edge after change", 32'(d), 32'(prev));
                rd_byte(da(p), 1'b1, d);
                chk(d == 8'(v), "R5 pin read after sync", 32'(d), 32'(v));
            end
        end

        // R8: bit writes merge from latch while pads show the opposite
        for (int p = 0; p < NP; p++) begin
            wr_byte(da(p), 8'h5A);
            m_latch[p] = 8'h5A;
            for (int b = 0; b < PW; b++) begin
                for (int s = 0; s < 2; s++) begin
                    logic nv;
                    nv = (s == 0) ? ~m_latch[p][b] : m_latch[p][b];
                    pad_in = {NP{~m_latch[p]}};
                    wr_bit(da(p) + 8'(b), nv);
                    m_latch[p][b] = nv;
                    rd_byte(da(p), 1'b0, d);
                    chk(d == m_latch[p], "R8 bit write result", 32'(d), 32'(m_latch[p]));
                end
            end
            check_pads("R8 pads after bit writes");
        end

        // R9: strobes during busy are ignored
        @(negedge clk);
        bit_addr = da(0) + 8'd3; bit_val = ~m_latch[0][3]; bit_wr = 1'b1;
        @(negedge clk);
        bit_wr = 1'b0;
        sfr_addr = da(2); sfr_wdata = ~m_latch[2]; sfr_wr = 1'b1; sfr_rd = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; sfr_rd = 1'b0;
        m_latch[0][3] = ~m_latch[0][3];
        chk(rd_valid == 1'b0, "R9 read during busy ignored", 32'(rd_valid), 32'd0);
        check_pads("R9 write during busy ignored");
        @(negedge clk);
        bit_addr = da(1); bit_val = ~m_latch[1][0]; bit_wr = 1'b1;
        @(negedge clk);
        bit_addr = da(1) + 8'd1; bit_val = ~m_latch[1][1];
        @(negedge clk);
        bit_wr = 1'b0;
        m_latch[1][0] = ~m_latch[1][0];
        chk(busy == 1'b0, "R9 bit write during busy ignored", 32'(busy), 32'd0);
        check_pads("R9 second bit write ignored");

        // R11: unmapped addresses
        wr_byte(8'h81, 8'h00);
        wr_byte(8'hB5, 8'hFF);
        wr_byte(8'h00, 8'h00);
        wr_byte(8'hB1, 8'hFF);
        check_regs("R11 unmapped writes");
        rd_byte(8'h81, 1'b1, d);
        chk(d == 8'h00, "R11 unmapped read", 32'(d), 32'd0);
        @(negedge clk);
        bit_addr = 8'h88; bit_val = 1'b0; bit_wr = 1'b1;
        @(negedge clk);
        bit_wr = 1'b0;
        chk(busy == 1'b0, "R11 out-of-range bit write", 32'(busy), 32'd0);
        check_pads("R11 out-of-range bit write");

        // R12: priority among simultaneous strobes
        @(negedge clk);
        sfr_addr = da(0); sfr_wdata = 8'h33; sfr_wr = 1'b1; sfr_rd = 1'b1;
        bit_addr = da(1); bit_val = ~m_latch[1][0]; bit_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; sfr_rd = 1'b0; bit_wr = 1'b0;
        m_latch[0] = 8'h33;
        chk(busy == 1'b0, "R12 write beats bit write", 32'(busy), 32'd0);
        chk(rd_valid == 1'b0, "R12 write beats read", 32'(rd_valid), 32'd0);
        check_pads("R12 only byte write taken");
        @(negedge clk);
        sfr_addr = da(2); sfr_rd = 1'b1;
        bit_addr = da(1) + 8'd2; bit_val = ~m_latch[1][2]; bit_wr = 1'b1;
        @(negedge clk);
        sfr_rd = 1'b0; bit_wr = 1'b0;
        chk(busy == 1'b1, "R12 bit write beats read", 32'(busy), 32'd1);
        chk(rd_valid == 1'b0, "R12 read dropped", 32'(rd_valid), 32'd0);
        @(negedge clk);
        m_latch[1][2] = ~m_latch[1][2];
        check_pads("R12 bit write taken");

        // R7: single-cycle valid, data held
        rd_byte(da(0), 1'b0, d);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R7 rd_valid one cycle", 32'(rd_valid), 32'd0);
        chk(sfr_rdata == d, "R7 rdata held", 32'(sfr_rdata), 32'(d));
        repeat (2) @(negedge clk);
        chk(sfr_rdata == d, "R7 rdata held later", 32'(sfr_rdata), 32'(d));

        // R10: alternate function override sweep
        wr_byte(pa(1), 8'hC3);
        m_pull[1] = 8'hC3;
        for (int j = 0; j < 32; j++) begin
            @(negedge clk);
            alt_en = TOT'(j * 24'h2D4B1F);
            alt_oe = TOT'(j * 24'h1B3A77);
            alt_do = TOT'(j * 24'h355C29);
            check_pads("R10 alternate override");
        end
        check_regs("R10 latches untouched");
        alt_en = '0;
        check_pads("R10 released");

        rd_byte(da(2), 1'b0, d2);
        chk(d2 == m_latch[2], "R6 final latch", 32'(d2), 32'(m_latch[2]));
        summary_and_end();
    end
endmodule